// File: doc/BRIEF.md
# Boundary Wrapper with Self-Holding Shared Cells

This block wraps a small core behind a ring of boundary registers. Each register does its normal job when the chip runs and also serves as a test wrapper cell. The registers loaded from the core's input ports form one scan chain, called the input chain. The registers that drive the output ports form a second chain, called the output chain. Each chain has its own scan enable, scan input and scan output. One slow input port is not shared with a functional register. It is cut off by a dedicated register that is added to the end of the input chain.

Each shared cell has a recirculation multiplexer in front of its capture path. During a capture cycle, a test mode can tell a chain to keep its contents. The cells then reload their own outputs. The scan enable stays low, so the path from the neighbouring cell into the scan input never has to meet at-speed timing. Unknown values on the ports are still kept out of the core.

- Internal test mode holds the input chain and lets the output chain observe the core.
- External test mode holds the output chain, so that it drives the ports, and lets the input chain sample the ports.

A parameter selects how the scan enables reach the cells:
- Launch-on-capture (the default): one hold decision is made per chain.
- Launch-on-shift: both scan enables first pass through a pipeline register.

Top module: `shared_wrap_core`

## Requirements
- R1: While `rstN` is low, every wrapper cell clears to 0, so `portOut`, `inWrapSo` and `outWrapSo` all read 0.
- R2: With `intestEn`, `extestEn`, `inWrapSe` and `outWrapSe` all low:
  - each input cell loads its `portIn` bit, and the dedicated cell loads `slowIn`, on every edge;
  - each output cell loads the core result `core[j] = a[j mod NUM_IN] ^ (a[(j+1) mod NUM_IN] & s)`, where `a` is the input cells and `s` is the dedicated cell;
  - so `portOut` follows the ports two edges later.
- R3: With `intestEn` high and `inWrapSe` low, the input cells and the dedicated cell keep their values, while the output cells still load the core result.
- R4: With `extestEn` high and `outWrapSe` low, the output cells keep their values, while the input cells still load the ports.
- R5: With `outWrapSe` high, the output chain shifts on every edge whatever the test enables are:
  - `outWrapSi` enters output cell 0;
  - cell k loads cell k-1;
  - `outWrapSo` is the last cell;
  - `portOut[k]` is output cell k.
- R6: With `inWrapSe` high, the input chain shifts on every edge whatever the test enables are. Bits move in the order `inWrapSi`, input cell 0 through NUM_IN-1, dedicated cell, `inWrapSo`, so the chain is NUM_IN+1 cells long.
- R7: During an internal-test capture, unknown values on `portIn` and `slowIn` reach no cell. No X appears on `portOut`, `outWrapSo` or `inWrapSo`.
- R8: With both test enables high and both scan enables low, both chains hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| intestEn | input | 1 | Internal test mode enable |
| extestEn | input | 1 | External test mode enable |
| inWrapSe | input | 1 | Input chain scan enable |
| outWrapSe | input | 1 | Output chain scan enable |
| inWrapSi | input | 1 | Input chain scan input |
| outWrapSi | input | 1 | Output chain scan input |
| portIn | input | NUM_IN | Core input ports |
| slowIn | input | 1 | Slow input port behind the dedicated cell |
| portOut | output | NUM_OUT | Core output ports, driven by the output cells |
| inWrapSo | output | 1 | Input chain scan output |
| outWrapSo | output | 1 | Output chain scan output |

## Verification
In the default variant, every cell responds at the first rising edge after its controls and data are applied. Timing therefore works out as follows:
- `inWrapSo` and the output-chain values are due one edge after the stimulus.
- A port change reaches `portOut` two edges later, once through the input cells and once through the output cells.

The bench drives inputs at the falling edge. A reference model advances exactly one step per rising edge. All outputs are compared a quarter period after that edge. Each comparison is therefore against the model state for the edge that has just passed.

// File: rtl/wrap_pkg.sv
package wrap_pkg;
  // strobes from the control to the datapath, one set per chain
  typedef struct packed {
    logic inShift;
    logic inHold;
    logic outShift;
    logic outHold;
  } wrapStrobeT;
endpackage

// File: rtl/shared_cell.sv
module shared_cell (
  input  logic clk,
  input  logic rstN,
  input  logic shiftEn,
  input  logic holdEn,
  input  logic funcD,
  input  logic scanD,
  output logic q
);
  logic capD;
  logic nxtD;

  // recirculation mux: the hold path loops q back, so scanD is only used in shift
  assign capD = holdEn ? q : funcD;
  assign nxtD = shiftEn ? scanD : capD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= 1'b0;
    else       q <= nxtD;
  end
endmodule

// File: rtl/core_cone.sv
module core_cone #(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4
) (
  input  logic [NUM_IN-1:0]  coreIn,
  input  logic               slowBit,
  output logic [NUM_OUT-1:0] coreOut
);
  for (genvar j = 0; j < NUM_OUT; j++) begin : g_cone
    localparam int IDX_A = j % NUM_IN;
    localparam int IDX_B = (j + 1) % NUM_IN;
    assign coreOut[j] = coreIn[IDX_A] ^ (coreIn[IDX_B] & slowBit);
  end
endmodule

// File: rtl/wrap_ctrl.sv
module wrap_ctrl
  import wrap_pkg::*;
#(
  parameter bit LOS = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       intestEn,
  input  logic       extestEn,
  input  logic       inWrapSe,
  input  logic       outWrapSe,
  output wrapStrobeT strobe
);
  logic inSeEff;
  logic outSeEff;

  if (LOS) begin : g_los
    // launch-on-shift: scan enables come through a pipeline register
    logic inSeQ;
    logic outSeQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inSeQ  <= 1'b0;
        outSeQ <= 1'b0;
      end else begin
        inSeQ  <= inWrapSe;
        outSeQ <= outWrapSe;
      end
    end
    assign inSeEff  = inSeQ;
    assign outSeEff = outSeQ;
  end else begin : g_loc
    // launch-on-capture: one combinational hold decision per chain
    logic unusedClkRst;
    assign unusedClkRst = clk ^ rstN;
    assign inSeEff  = inWrapSe;
    assign outSeEff = outWrapSe;
  end

  always_comb begin
    strobe.inShift  = inSeEff;
    strobe.inHold   = intestEn & ~inSeEff;
    strobe.outShift = outSeEff;
    strobe.outHold  = extestEn & ~outSeEff;
  end
endmodule

// File: rtl/wrap_datapath.sv
module wrap_datapath
  import wrap_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  wrapStrobeT         strobe,
  input  logic               inWrapSi,
  input  logic               outWrapSi,
  input  logic [NUM_IN-1:0]  portIn,
  input  logic               slowIn,
  output logic [NUM_OUT-1:0] portOut,
  output logic               inWrapSo,
  output logic               outWrapSo
);
  localparam int IN_LEN = NUM_IN + 1;  // shared cells plus the dedicated cell

  logic [IN_LEN-1:0]  inChain;
  logic [IN_LEN-1:0]  inScan;
  logic [IN_LEN-1:0]  inFunc;
  logic [NUM_OUT-1:0] outChain;
  logic [NUM_OUT-1:0] outScan;
  logic [NUM_OUT-1:0] coreOut;

  assign inFunc = {slowIn, portIn};
  assign inScan = {inChain[IN_LEN-2:0], inWrapSi};

  for (genvar k = 0; k < IN_LEN; k++) begin : g_in
    shared_cell uCell (
      .clk(clk), .rstN(rstN),
      .shiftEn(strobe.inShift), .holdEn(strobe.inHold),
      .funcD(inFunc[k]), .scanD(inScan[k]), .q(inChain[k])
    );
  end

  core_cone #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) uCone (
    .coreIn(inChain[NUM_IN-1:0]),
    .slowBit(inChain[IN_LEN-1]),
    .coreOut(coreOut)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    if (k == 0) begin : g_first
      assign outScan[k] = outWrapSi;
    end else begin : g_rest
      assign outScan[k] = outChain[k-1];
    end
    shared_cell uCell (
      .clk(clk), .rstN(rstN),
      .shiftEn(strobe.outShift), .holdEn(strobe.outHold),
      .funcD(coreOut[k]), .scanD(outScan[k]), .q(outChain[k])
    );
  end

  assign portOut   = outChain;
  assign inWrapSo  = inChain[IN_LEN-1];
  assign outWrapSo = outChain[NUM_OUT-1];
endmodule

// File: rtl/shared_wrap_core.sv
module shared_wrap_core
  import wrap_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4,
  parameter bit LOS     = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               intestEn,
  input  logic               extestEn,
  input  logic               inWrapSe,
  input  logic               outWrapSe,
  input  logic               inWrapSi,
  input  logic               outWrapSi,
  input  logic [NUM_IN-1:0]  portIn,
  input  logic               slowIn,
  output logic [NUM_OUT-1:0] portOut,
  output logic               inWrapSo,
  output logic               outWrapSo
);
  wrapStrobeT strobe;

  wrap_ctrl #(.LOS(LOS)) uCtrl (
    .clk(clk), .rstN(rstN),
    .intestEn(intestEn), .extestEn(extestEn),
    .inWrapSe(inWrapSe), .outWrapSe(outWrapSe),
    .strobe(strobe)
  );

  wrap_datapath #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .inWrapSi(inWrapSi), .outWrapSi(outWrapSi),
    .portIn(portIn), .slowIn(slowIn),
    .portOut(portOut), .inWrapSo(inWrapSo), .outWrapSo(outWrapSo)
  );
endmodule

// File: rtl/shared_wrap_core_chk.sv
module shared_wrap_core_chk #(
  parameter int NUM_OUT = 4,
  parameter bit LOS     = 1'b0
) (
  input logic               clk,
  input logic               rstN,
  input logic               intestEn,
  input logic               extestEn,
  input logic               inWrapSe,
  input logic               outWrapSe,
  input logic               outWrapSi,
  input logic [NUM_OUT-1:0] portOut,
  input logic               inWrapSo,
  input logic               outWrapSo
);
  // R3
  intest_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((LOS == 1'b0) && intestEn && !inWrapSe) |=> $stable(inWrapSo));

  // R4
  extest_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((LOS == 1'b0) && extestEn && !outWrapSe) |=> $stable(portOut));

  // R5
  out_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((LOS == 1'b0) && outWrapSe) |=> (portOut[0] == $past(outWrapSi)));

  // R7
  no_x_chk: assert property (@(posedge clk) disable iff (!rstN)
    intestEn |-> !$isunknown({portOut, outWrapSo, inWrapSo}));
endmodule

bind shared_wrap_core shared_wrap_core_chk #(.NUM_OUT(NUM_OUT), .LOS(LOS)) uChk (
  .clk(clk), .rstN(rstN), .intestEn(intestEn), .extestEn(extestEn),
  .inWrapSe(inWrapSe), .outWrapSe(outWrapSe), .outWrapSi(outWrapSi),
  .portOut(portOut), .inWrapSo(inWrapSo), .outWrapSo(outWrapSo)
);

// File: tb/sim_shared_wrap_core.sv
module sim_shared_wrap_core;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int NO = 4;

  logic clk = 1'b0;
  logic rstN;
  logic intestEn, extestEn, inWrapSe, outWrapSe, inWrapSi, outWrapSi, slowIn;
  logic [NI-1:0] portIn;
  logic [NO-1:0] portOut;
  logic inWrapSo, outWrapSo;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [NI-1:0] inM;
  logic          slowM;
  logic [NO-1:0] outM;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_wrap_core #(.NUM_IN(NI), .NUM_OUT(NO)) u0 (
    .clk(clk), .rstN(rstN), .intestEn(intestEn), .extestEn(extestEn),
    .inWrapSe(inWrapSe), .outWrapSe(outWrapSe), .inWrapSi(inWrapSi),
    .outWrapSi(outWrapSi), .portIn(portIn), .slowIn(slowIn),
    .portOut(portOut), .inWrapSo(inWrapSo), .outWrapSo(outWrapSo)
  );

  function automatic logic [NO-1:0] coreModel(logic [NI-1:0] a, logic s);
    logic [NO-1:0] r;
    for (int j = 0; j < NO; j++) r[j] = a[j % NI] ^ (a[(j + 1) % NI] & s);
    return r;
  endfunction

  task automatic chk(string tag, logic [NO-1:0] act, logic [NO-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive at falling edge, model steps at rising edge, compare after it
  task automatic step(logic ie, logic ee, logic ise, logic ose, logic isi, logic osi,
                      logic [NI-1:0] pin, logic sin, bit xPorts);
    logic [NI-1:0] nIn;
    logic          nSlow;
    logic [NO-1:0] nOut;
    string tagIn, tagOut;
    intestEn = ie; extestEn = ee; inWrapSe = ise; outWrapSe = ose;
    inWrapSi = isi; outWrapSi = osi;
    portIn = xPorts ? 'x : pin;
    slowIn = xPorts ? 1'bx : sin;
    @(posedge clk);
    if (ise) begin
      nIn[0] = isi;
      for (int k = 1; k < NI; k++) nIn[k] = inM[k-1];
      nSlow = inM[NI-1];
      tagIn = "R6";
    end else if (ie) begin
      nIn = inM; nSlow = slowM;
      tagIn = xPorts ? "R7" : (ee ? "R8" : "R3");
    end else begin
      nIn = pin; nSlow = sin; tagIn = ee ? "R4" : "R2";
    end
    if (ose) begin
      nOut[0] = osi;
      for (int k = 1; k < NO; k++) nOut[k] = outM[k-1];
      tagOut = "R5";
    end else if (ee) begin
      nOut = outM; tagOut = ie ? "R8" : "R4";
    end else begin
      nOut = coreModel(inM, slowM);
      tagOut = ie ? (xPorts ? "R7" : "R3") : "R2";
    end
    inM = nIn; slowM = nSlow; outM = nOut;
    #(CLK_PERIOD/4);
    chk(tagOut, portOut, outM);
    chk(tagOut, {{(NO-1){1'b0}}, outWrapSo}, {{(NO-1){1'b0}}, outM[NO-1]});
    chk(tagIn, {{(NO-1){1'b0}}, inWrapSo}, {{(NO-1){1'b0}}, slowM});
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NI:0] pat;
    void'($urandom(32'h5eed_c0de));
    rstN = 1'b0; intestEn = 0; extestEn = 0; inWrapSe = 0; outWrapSe = 0;
    inWrapSi = 0; outWrapSi = 0; portIn = '1; slowIn = 1;
    inM = '0; slowM = 0; outM = '0;
    repeat (3) @(negedge clk);
    // R1: cleared while reset is held
    chk("R1", portOut, '0);
    chk("R1", {{(NO-1){1'b0}}, inWrapSo}, '0);
    chk("R1", {{(NO-1){1'b0}}, outWrapSo}, '0);
    rstN = 1'b1;

    // R2: functional flow through both cell rows
    step(0,0,0,0,0,0, 4'b1011, 1, 0);
    step(0,0,0,0,0,0, 4'b0110, 0, 0);
    step(0,0,0,0,0,0, 4'b0110, 0, 0);

    // R6 then R3/R7: load a known pattern, capture with unknown ports, unload
    pat = 5'b10110;
    for (int k = 0; k <= NI; k++) step(1,0,1,0, pat[k],0, 'x, 1'bx, 1);
    for (int k = 0; k < 3; k++) step(1,0,0,0, 0,0, '0, 0, 1);
    for (int k = 0; k <= NI; k++) step(1,0,1,0, 0,0, '0, 0, 1);

    // R5 then R4: load the output chain, capture with it held
    for (int k = 0; k < NO; k++) step(0,1,0,1, 0, k[0], 4'b1001, 1, 0);
    step(0,1,0,0, 0,0, 4'b0101, 1, 0);
    step(0,1,0,0, 0,0, 4'b1110, 0, 0);

    // R8: both modes at once hold both chains
    step(1,1,0,0, 0,0, 4'b0001, 1, 0);
    step(1,1,0,0, 0,0, 4'b1000, 0, 0);

    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      logic ie, ee, ise, ose;
      bit xp;
      ie  = 1'($urandom); ee = 1'($urandom);
      ise = 1'($urandom); ose = 1'($urandom);
      xp  = ie && !ise && (($urandom % 2) == 0);
      step(ie, ee, ise, ose, 1'($urandom), 1'($urandom), NI'($urandom), 1'($urandom), xp);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule